// File: doc/BRIEF.md
# Accumulator Rotate and Decimal Adjust Unit

This unit carries out the single-byte accumulator operations of an 8-bit processor datapath. There are four one-bit rotates and a BCD decimal adjust. The controlling sequencer presents the accumulator, the five status flags and a 3-bit operation code, then pulses `start_i` for one cycle. The unit captures these operands and stays busy for a fixed four-cycle operation time. It then updates its registered result outputs and pulses `done_o` for one cycle.

The rotates come in two flavours. A circular rotate copies the bit leaving one end into both the other end and the carry. A rotate through carry treats the carry as a ninth bit of the ring. The decimal adjust turns the binary sum of two packed BCD bytes back into packed BCD. It applies a +6 correction per nibble and then recomputes sign, zero, parity, auxiliary carry and carry.

Top module: `acc_rot_daa`

## Requirements
- R1: While reset is asserted, and right after it, `busy_o`, `done_o`, `acc_o` and every flag output are 0.
- R2: Op code 0 (rotate left circular) gives `acc_o` = {A[6:0],A[7]} and `cy_o` = A[7].
- R3: Op code 1 (rotate right circular) gives `acc_o` = {A[0],A[7:1]} and `cy_o` = A[0].
- R4: Op code 2 (rotate left through carry) gives `acc_o` = {A[6:0],CY} and `cy_o` = A[7].
- R5: Op code 3 (rotate right through carry) gives `acc_o` = {CY,A[7:1]} and `cy_o` = A[0].
- R6: For op codes 0 to 3, `ac_o`, `sign_o`, `zero_o` and `par_o` equal the flag inputs captured at the accepted start.
- R7: Op code 4 (decimal adjust) adds 6 when A[3:0] > 9 or AC is set. `ac_o` is the carry out of bit 3 of that addition, and 0 when no addition is made.
- R8: In the decimal adjust, 0x60 is then added when the intermediate's upper part (bits 8..4) exceeds 9 or CY is set. `cy_o` is 1 if the result overflows bit 7 or CY was 1, so an input carry is never cleared.
- R9: After the decimal adjust, `sign_o` = result bit 7, `zero_o` = 1 exactly when the result is 0x00, and `par_o` = 1 when the result has an even number of one bits.
- R10: Start is accepted when `start_i` is high and `busy_o` is low. `busy_o` is high from the next cycle on, and `done_o` pulses for exactly one cycle 4 clock edges after the accepting edge. At that edge the result outputs update, and they hold their value at all other times.
- R11: A `start_i` pulse while `busy_o` is high is ignored: the running operation completes with its own operands and no extra result follows.
- R12: Op codes 5, 6 and 7 return the captured accumulator and all five flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 3 | Operation code (0..4 defined, 5..7 pass-through) |
| acc_i | input | 8 | Accumulator operand |
| cy_i | input | 1 | Carry flag in |
| ac_i | input | 1 | Auxiliary carry flag in |
| sign_i | input | 1 | Sign flag in |
| zero_i | input | 1 | Zero flag in |
| par_i | input | 1 | Parity flag in |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| acc_o | output | 8 | Resulting accumulator |
| cy_o | output | 1 | Resulting carry |
| ac_o | output | 1 | Resulting auxiliary carry |
| sign_o | output | 1 | Resulting sign |
| zero_o | output | 1 | Resulting zero |
| par_o | output | 1 | Resulting parity |

## Verification
The assertions run on every cycle and check the following. The done strobe is a single pulse that comes exactly four edges after acceptance and only ends a busy period. The outputs hold still between strobes. The flag behaviour can be seen from the outputs alone: a rotate keeps the untouched flags, the rotated-out bit lands in carry for the circular forms, and the decimal adjust's sign, zero and parity agree with its result and keep an input carry. The actual nibble arithmetic can be shown only by the bench's scenarios. These are the low-only, high-only and double corrections, the wrap past 0xFF and the zero result. The bench scenarios also cover the through-carry rotates at their edge bits, the pass-through codes, and a start request dropped while busy.

// File: rtl/acc_rot_daa_pkg.sv
package acc_rot_daa_pkg;

    localparam int ACC_W = 8;
    localparam int NIB_W = ACC_W / 2;
    localparam int OP_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_RLC = 3'd0,
        OP_RRC = 3'd1,
        OP_RAL = 3'd2,
        OP_RAR = 3'd3,
        OP_DAA = 3'd4
    } op_e;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             cy;
        logic             ac;
        logic             sgn;
        logic             zro;
        logic             par;
    } flag_set_t;

    typedef struct packed {
        logic [OP_W-1:0] op;
        flag_set_t       val;
    } opnd_t;

endpackage

// File: rtl/ard_rotator.sv
module ard_rotator
    import acc_rot_daa_pkg::*;
(
    input  logic [1:0]       mode_i,   // bit0: right, bit1: through carry
    input  logic [ACC_W-1:0] acc_i,
    input  logic             cy_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             cy_o
);
    logic right;
    logic thru;
    logic fill_bit;

    assign right = mode_i[0];
    assign thru  = mode_i[1];

    always_comb begin
        if (thru)
            fill_bit = cy_i;
        else if (right)
            fill_bit = acc_i[0];
        else
            fill_bit = acc_i[ACC_W-1];

        if (right) begin
            acc_o = {fill_bit, acc_i[ACC_W-1:1]};
            cy_o  = acc_i[0];
        end else begin
            acc_o = {acc_i[ACC_W-2:0], fill_bit};
            cy_o  = acc_i[ACC_W-1];
        end
    end
endmodule

// File: rtl/ard_decadj.sv
module ard_decadj
    import acc_rot_daa_pkg::*;
(
    input  logic [ACC_W-1:0] acc_i,
    input  logic             cy_i,
    input  logic             ac_i,
    output flag_set_t        res_o
);
    localparam logic [NIB_W:0]   LIMIT    = (NIB_W+1)'(9);
    localparam logic [ACC_W:0]   LO_ADD   = (ACC_W+1)'(6);
    localparam logic [ACC_W:0]   HI_ADD   = (ACC_W+1)'(6) << NIB_W;

    logic             lo_fix;
    logic             hi_fix;
    logic [NIB_W:0]   lo_sum;
    logic [ACC_W:0]   stage1;
    logic [ACC_W:0]   stage2;
    logic [NIB_W:0]   upper;

    always_comb begin
        lo_fix = ({1'b0, acc_i[NIB_W-1:0]} > LIMIT) || ac_i;
        lo_sum = {1'b0, acc_i[NIB_W-1:0]} + (NIB_W+1)'(6);
        stage1 = {1'b0, acc_i} + (lo_fix ? LO_ADD : '0);
        upper  = stage1[ACC_W:NIB_W];
        hi_fix = (upper > LIMIT) || cy_i;
        stage2 = stage1 + (hi_fix ? HI_ADD : '0);

        res_o.acc = stage2[ACC_W-1:0];
        res_o.ac  = lo_fix & lo_sum[NIB_W];
        res_o.cy  = cy_i | stage2[ACC_W];
        res_o.sgn = stage2[ACC_W-1];
        res_o.zro = (stage2[ACC_W-1:0] == '0);
        res_o.par = ~^stage2[ACC_W-1:0];
    end
endmodule

// File: rtl/ard_op_timer.sv
module ard_op_timer #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic fire_o,
    output logic busy_o
);
    localparam int CNT_W = (LAT > 2) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        accept_o = start_i && !tmr_q.busy;
        fire_o   = tmr_q.busy && (tmr_q.cnt == '0);
        if (accept_o) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(LAT - 1);
        end else if (fire_o) begin
            tmr_d.busy = 1'b0;
        end else if (tmr_q.busy) begin
            tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;
endmodule

// File: rtl/acc_rot_daa.sv
module acc_rot_daa
    import acc_rot_daa_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic             cy_i,
    input  logic             ac_i,
    input  logic             sign_i,
    input  logic             zero_i,
    input  logic             par_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [ACC_W-1:0] acc_o,
    output logic             cy_o,
    output logic             ac_o,
    output logic             sign_o,
    output logic             zero_o,
    output logic             par_o
);
    typedef struct packed {
        opnd_t     opnd;
        flag_set_t res;
        logic      done;
    } unit_t;

    unit_t st_d, st_q;

    logic             accept;
    logic             fire;
    logic [ACC_W-1:0] rot_acc;
    logic             rot_cy;
    flag_set_t        daa_res;
    flag_set_t        next_res;

    ard_op_timer #(.LAT(LATENCY)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .fire_o   (fire),
        .busy_o   (busy_o)
    );

    ard_rotator rot_i (
        .mode_i (st_q.opnd.op[1:0]),
        .acc_i  (st_q.opnd.val.acc),
        .cy_i   (st_q.opnd.val.cy),
        .acc_o  (rot_acc),
        .cy_o   (rot_cy)
    );

    ard_decadj daa_i (
        .acc_i (st_q.opnd.val.acc),
        .cy_i  (st_q.opnd.val.cy),
        .ac_i  (st_q.opnd.val.ac),
        .res_o (daa_res)
    );

    always_comb begin
        next_res = st_q.opnd.val;
        case (st_q.opnd.op)
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                next_res.acc = rot_acc;
                next_res.cy  = rot_cy;
            end
            OP_DAA:  next_res = daa_res;
            default: next_res = st_q.opnd.val;
        endcase

        st_d      = st_q;
        st_d.done = fire;
        if (accept) begin
            st_d.opnd.op      = op_i;
            st_d.opnd.val.acc = acc_i;
            st_d.opnd.val.cy  = cy_i;
            st_d.opnd.val.ac  = ac_i;
            st_d.opnd.val.sgn = sign_i;
            st_d.opnd.val.zro = zero_i;
            st_d.opnd.val.par = par_i;
        end
        if (fire)
            st_d.res = next_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign acc_o  = st_q.res.acc;
    assign cy_o   = st_q.res.cy;
    assign ac_o   = st_q.res.ac;
    assign sign_o = st_q.res.sgn;
    assign zero_o = st_q.res.zro;
    assign par_o  = st_q.res.par;
endmodule

// File: rtl/ard_checker.sv
module ard_checker
    import acc_rot_daa_pkg::*;
#(
    parameter int LAT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [OP_W-1:0]  op_i,
    input logic             ac_i,
    input logic             cy_i,
    input logic             sign_i,
    input logic             zero_i,
    input logic             par_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [ACC_W-1:0] acc_o,
    input logic             cy_o,
    input logic             ac_o,
    input logic             sign_o,
    input logic             zero_o,
    input logic             par_o
);
    logic [OP_W-1:0] op_q;
    logic            ac_q, cy_q, s_q, z_q, p_q;
    int unsigned     gap_q;
    logic            is_rot, is_daa;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            ac_q  <= 1'b0;
            cy_q  <= 1'b0;
            s_q   <= 1'b0;
            z_q   <= 1'b0;
            p_q   <= 1'b0;
            gap_q <= 0;
        end else if (start_i && !busy_o) begin
            op_q  <= op_i;
            ac_q  <= ac_i;
            cy_q  <= cy_i;
            s_q   <= sign_i;
            z_q   <= zero_i;
            p_q   <= par_i;
            gap_q <= 0;
        end else if (busy_o) begin
            gap_q <= gap_q + 1;
        end
    end

    assign is_rot = (op_q <= 3'd3);
    assign is_daa = (op_q == OP_DAA);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (gap_q == LAT));

    assert_busy_ends_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> (busy_o || done_o));

    assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(acc_o) && $stable(cy_o) && $stable(ac_o)));

    assert_rot_keeps_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && is_rot) |-> (sign_o == s_q && zero_o == z_q && par_o == p_q && ac_o == ac_q));

    assert_rlc_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_RLC) |-> (cy_o == acc_o[0]));

    assert_rrc_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_RRC) |-> (cy_o == acc_o[ACC_W-1]));

    assert_daa_keep_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && is_daa && cy_q) |-> cy_o);

    assert_daa_szp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && is_daa) |-> (zero_o == (acc_o == '0) && sign_o == acc_o[ACC_W-1]
                                && par_o == ~^acc_o));

    assert_pass_through_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q > 3'd4) |-> (cy_o == cy_q && ac_o == ac_q && sign_o == s_q));
endmodule

bind acc_rot_daa ard_checker #(.LAT(LATENCY)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .ac_i    (ac_i),
    .cy_i    (cy_i),
    .sign_i  (sign_i),
    .zero_i  (zero_i),
    .par_i   (par_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .acc_o   (acc_o),
    .cy_o    (cy_o),
    .ac_o    (ac_o),
    .sign_o  (sign_o),
    .zero_o  (zero_o),
    .par_o   (par_o)
);

// File: tb/acc_rot_daa_tb_top.sv
module acc_rot_daa_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic       cy_i = 1'b0, ac_i = 1'b0, sign_i = 1'b0, zero_i = 1'b0, par_i = 1'b0;
    logic       busy_o, done_o;
    logic [7:0] acc_o;
    logic       cy_o, ac_o, sign_o, zero_o, par_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [12:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_rot_daa #(.LATENCY(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .acc_i(acc_i),
        .cy_i(cy_i), .ac_i(ac_i), .sign_i(sign_i), .zero_i(zero_i), .par_i(par_i),
        .busy_o(busy_o), .done_o(done_o), .acc_o(acc_o), .cy_o(cy_o), .ac_o(ac_o),
        .sign_o(sign_o), .zero_o(zero_o), .par_o(par_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    // expected {acc, cy, ac, sign, zero, parity}
    function automatic logic [12:0] model(input logic [2:0] op, input logic [7:0] a,
                                          input logic cy, input logic ac, input logic s,
                                          input logic z, input logic p);
        logic [7:0] r;
        logic       ncy, nac, ns, nz, np;
        int         t, lo, hi;
        r = a; ncy = cy; nac = ac; ns = s; nz = z; np = p;
        case (op)
            3'd0: begin r = {a[6:0], a[7]}; ncy = a[7]; end
            3'd1: begin r = {a[0], a[7:1]}; ncy = a[0]; end
            3'd2: begin r = {a[6:0], cy};   ncy = a[7]; end
            3'd3: begin r = {cy, a[7:1]};   ncy = a[0]; end
            3'd4: begin
                lo = int'(a) % 16;
                t = int'(a);
                nac = 1'b0;
                if (lo > 9 || ac) begin
                    t = t + 6;
                    nac = (lo + 6) > 15;
                end
                hi = t / 16;
                if (hi > 9 || cy) t = t + 96;
                ncy = cy || (t > 255);
                r = 8'(t % 256);
                ns = r[7];
                nz = (r == 8'h00);
                np = ~^r;
            end
            default: ;
        endcase
        return {r, ncy, nac, ns, nz, np};
    endfunction

    // drive one operation; optional ignored second start mid-operation
    task automatic issue(input string tag, input logic [2:0] op, input logic [7:0] a,
                         input logic cy, input logic ac, input logic s, input logic z,
                         input logic p, input bit poke_busy);
        exp_q.push_back(model(op, a, cy, ac, s, z, p));
        tag_q.push_back(tag);
        @(negedge clk);
        op_i = op; acc_i = a; cy_i = cy; ac_i = ac; sign_i = s; zero_i = z; par_i = p;
        start_i = 1'b1;
        @(posedge clk); #1;
        check({tag, " R10 busy after accept"}, {15'd0, busy_o}, 16'd1);
        @(negedge clk);
        start_i = 1'b0;
        op_i = ~op; acc_i = ~a; cy_i = ~cy; ac_i = ~ac; sign_i = ~s; zero_i = ~z; par_i = ~p;
        for (int i = 1; i < LAT; i++) begin
            if (poke_busy && i == 2) begin
                @(negedge clk);
                start_i = 1'b1;   // R11: must be ignored
                op_i = 3'd4;
                @(posedge clk); #1;
                @(negedge clk);
                start_i = 1'b0;
            end else begin
                @(posedge clk); #1;
            end
            check({tag, " R10 no early done"}, {15'd0, done_o}, 16'd0);
        end
        @(posedge clk); #1;
        check({tag, " R10 done on 4th edge"}, {14'd0, done_o, busy_o}, 16'b10);
        @(posedge clk); #1;
        check({tag, " R10 done single pulse"}, {15'd0, done_o}, 16'd0);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && done_o) begin
                if (exp_q.size() == 0) begin
                    n_checks++;
                    n_fails++;
                    $display("FAIL R11: unexpected result actual %h expected none",
                             {acc_o, cy_o, ac_o, sign_o, zero_o, par_o});
                end else begin
                    automatic logic [12:0] e = exp_q.pop_front();
                    automatic string       t = tag_q.pop_front();
                    check(t, {3'd0, acc_o, cy_o, ac_o, sign_o, zero_o, par_o}, {3'd0, e});
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", {6'd0, busy_o, done_o, acc_o}, 16'd0);
        check("R1 reset flags", {11'd0, cy_o, ac_o, sign_o, zero_o, par_o}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", {6'd0, busy_o, done_o, acc_o}, 16'd0);

        issue("R2 rlc 85",   3'd0, 8'h85, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0);
        issue("R2 rlc 00",   3'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        issue("R3 rrc 01",   3'd1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        issue("R3 rrc 80",   3'd1, 8'h80, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0);
        issue("R4 ral 80",   3'd2, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        issue("R4 ral 01",   3'd2, 8'h01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 0);
        issue("R5 rar 01",   3'd3, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0);
        issue("R5 rar 00",   3'd3, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 0);
        issue("R6 rot flags", 3'd2, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 0);
        issue("R7 daa lo only", 3'd4, 8'h0C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0);
        issue("R7 daa ac in",   3'd4, 8'h15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
        issue("R8 daa both",    3'd4, 8'h9B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        issue("R8 daa wrap FA", 3'd4, 8'hFA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        issue("R8 daa keep cy", 3'd4, 8'h42, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        issue("R9 daa zero",    3'd4, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        issue("R9 daa 99",      3'd4, 8'h99, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0);
        for (int v = 0; v < 256; v += 23) begin
            issue("R8 daa sweep", 3'd4, 8'(v), v[0], v[1], 1'b0, 1'b0, 1'b0, 0);
        end
        issue("R12 code5", 3'd5, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        issue("R12 code6", 3'd6, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0);
        issue("R12 code7", 3'd7, 8'h81, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0);
        issue("R11 start ignored", 3'd0, 8'h41, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        repeat (8) @(posedge clk);
        #1;
        check("R11 idle after ignored start", {15'd0, busy_o}, 16'd0);
        check("R11 scoreboard drained", 16'(exp_q.size()), 16'd0);
        summary();
    end
endmodule